// File: doc/BRIEF.md
# Command-Driven Controller Status Flags

This block keeps the state flags of a serial controller: the enable flag, the master-select flag and six latched error flags. Software never writes a flag directly. Instead it writes a command word in which every flag owns one bit that sets it and one bit that clears it. The write takes effect at the next clock edge. Hardware error detectors can also raise the error flags. Each detector except the mode-error one is gated by its own enable input.

The flags, together with a live busy indication from the shifter, are visible in one 16-bit status word. Two flags are also brought out directly. The enable flag selects active mode (1) or configuration mode (0), and the master-select flag drives a master/slave output. An error interrupt is raised while any error flag is latched.

Top module: `sc_status_reg`

## Requirements
- R1: After reset every flag is 0: `status_word` reads 0 apart from bit 13, and `err_irq`, `active_mode` and `master_sel` are 0.
- R2: The status word layout is: enable at bit 0, master-select at bit 1, mode error at bit 7, transmit error at bit 8, receive error at bit 9, abort error at bit 10, transmit underflow at bit 11, receive underflow at bit 12. Bit 13 follows `busy_in` in the same cycle. Bits 6..2, 14 and 15 read 0.
- R3: When `cmd_wr` is high, command bits act as clear/set pairs in the next cycle. The pairs are enable 0/1, master-select 2/3, receive underflow 4/5, mode error 6/7, transmit error 8/12, receive error 9/13, abort error 10/14 and transmit underflow 11/15, each written as clear/set.
- R4: When `cmd_wr` is low, `cmd_data` has no effect on any flag.
- R5: If a command asserts both the set bit and the clear bit of one flag, that flag keeps its value.
- R6: `hw_err_evt` bits are [0] mode, [1] transmit, [2] receive, [3] abort, [4] transmit underflow and [5] receive underflow. `err_en` bits [0]..[4] enable events [1]..[5]. An enabled event latches its flag in the next cycle, and a disabled event is ignored. A mode event is always latched.
- R7: An enabled hardware event in the same cycle as a clear command for the same flag wins, so the flag ends up set.
- R8: The command value 0x0F50 clears all six error flags in one write and leaves enable and master-select unchanged.
- R9: `err_irq` is high exactly when at least one of the six error flags is set.
- R10: `active_mode` equals the enable flag (1 = active mode, 0 = configuration mode), and `master_sel` equals the master-select flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_wr | input | 1 | Command write strobe |
| cmd_data | input | 16 | Command word with per-flag set/clear bits |
| hw_err_evt | input | 6 | Hardware error events, one pulse per cycle |
| err_en | input | 5 | Error-check enables for the gated events |
| busy_in | input | 1 | Live busy indication from the shifter |
| status_word | output | 16 | Packed status word |
| err_irq | output | 1 | Error interrupt |
| active_mode | output | 1 | 1 = active mode, 0 = configuration mode |
| master_sel | output | 1 | Master-select flag |

## Verification
The checker tests several relations on every cycle. These are the one-cycle effect of single set and clear commands, flag stability when a set and a clear collide, event-over-clear priority, and the mode event that is always latched. It also checks that disabled events and unstrobed commands leave the flags untouched, and that the reserved bits, busy mirror and interrupt stay consistent with the status word. Multi-step histories need the bench scenarios: the full bit map walked flag by flag, the bulk error clear that spares enable and master-select, a mid-run reset, and several flags raised together by events.

// File: rtl/sc_status_pkg.sv
package sc_status_pkg;

  localparam int CMD_W      = 16;
  localparam int STAT_W     = 16;
  localparam int NUM_FLAGS  = 8;
  localparam int NUM_ERR    = 6;
  localparam int NUM_ERR_EN = NUM_ERR - 1;
  localparam int FIRST_ERR  = NUM_FLAGS - NUM_ERR;
  localparam int BUSY_POS   = 13;

  // flag order used inside the block
  typedef enum logic [2:0] {
    FL_EN  = 3'd0,
    FL_MS  = 3'd1,
    FL_ME  = 3'd2,
    FL_TE  = 3'd3,
    FL_RE  = 3'd4,
    FL_AE  = 3'd5,
    FL_TUE = 3'd6,
    FL_RUE = 3'd7
  } flag_e;

  function automatic int stat_pos(input int f);
    case (f)
      0: return 0;
      1: return 1;
      2: return 7;
      3: return 8;
      4: return 9;
      5: return 10;
      6: return 11;
      default: return 12;
    endcase
  endfunction

  function automatic int clr_pos(input int f);
    case (f)
      0: return 0;
      1: return 2;
      2: return 6;
      3: return 8;
      4: return 9;
      5: return 10;
      6: return 11;
      default: return 4;
    endcase
  endfunction

  function automatic int set_pos(input int f);
    case (f)
      0: return 1;
      1: return 3;
      2: return 7;
      3: return 12;
      4: return 13;
      5: return 14;
      6: return 15;
      default: return 5;
    endcase
  endfunction

endpackage

// File: rtl/sc_cmd_decode.sv
module sc_cmd_decode
  import sc_status_pkg::*;
(
  input  logic                 wr_i,
  input  logic [CMD_W-1:0]     cmd_i,
  output logic [NUM_FLAGS-1:0] set_o,
  output logic [NUM_FLAGS-1:0] clr_o
);

  for (genvar g = 0; g < NUM_FLAGS; g++) begin : g_pair
    assign set_o[g] = wr_i & cmd_i[set_pos(g)];
    assign clr_o[g] = wr_i & cmd_i[clr_pos(g)];
  end

endmodule

// File: rtl/sc_flag_cell.sv
module sc_flag_cell (
  input  logic clk,
  input  logic rst_n,
  input  logic set_i,
  input  logic clr_i,
  input  logic evt_i,
  output logic q_o
);

  logic nxt;

  // priority: event, then a lone set, then a lone clear, else hold
  always_comb begin
    nxt = q_o;
    if (evt_i)               nxt = 1'b1;
    else if (set_i && !clr_i) nxt = 1'b1;
    else if (clr_i && !set_i) nxt = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) q_o <= 1'b0;
    else        q_o <= nxt;
  end

endmodule

// File: rtl/sc_status_pack.sv
module sc_status_pack
  import sc_status_pkg::*;
(
  input  logic [NUM_FLAGS-1:0] flags_i,
  input  logic                 busy_i,
  output logic [STAT_W-1:0]    word_o,
  output logic                 irq_o
);

  always_comb begin
    word_o = '0;
    for (int f = 0; f < NUM_FLAGS; f++) begin
      word_o[stat_pos(f)] = flags_i[f];
    end
    word_o[BUSY_POS] = busy_i;
  end

  assign irq_o = |flags_i[NUM_FLAGS-1:FIRST_ERR];

endmodule

// File: rtl/sc_status_reg.sv
module sc_status_reg
  import sc_status_pkg::*;
(
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  cmd_wr,
  input  logic [CMD_W-1:0]      cmd_data,
  input  logic [NUM_ERR-1:0]    hw_err_evt,
  input  logic [NUM_ERR_EN-1:0] err_en,
  input  logic                  busy_in,
  output logic [STAT_W-1:0]     status_word,
  output logic                  err_irq,
  output logic                  active_mode,
  output logic                  master_sel
);

  logic [NUM_FLAGS-1:0] set_v;
  logic [NUM_FLAGS-1:0] clr_v;
  logic [NUM_FLAGS-1:0] evt_v;
  logic [NUM_FLAGS-1:0] flags;

  sc_cmd_decode u_dec (
    .wr_i  (cmd_wr),
    .cmd_i (cmd_data),
    .set_o (set_v),
    .clr_o (clr_v)
  );

  // event routing: control flags have no hardware source,
  // mode error is always checked, the rest are gated
  for (genvar g = 0; g < NUM_FLAGS; g++) begin : g_evt
    if (g < FIRST_ERR) begin : g_none
      assign evt_v[g] = 1'b0;
    end else if (g == FIRST_ERR) begin : g_always
      assign evt_v[g] = hw_err_evt[0];
    end else begin : g_gated
      assign evt_v[g] = hw_err_evt[g-FIRST_ERR] & err_en[g-FIRST_ERR-1];
    end
  end

  for (genvar g = 0; g < NUM_FLAGS; g++) begin : g_cell
    sc_flag_cell u_cell (
      .clk   (clk),
      .rst_n (rst_n),
      .set_i (set_v[g]),
      .clr_i (clr_v[g]),
      .evt_i (evt_v[g]),
      .q_o   (flags[g])
    );
  end

  sc_status_pack u_pack (
    .flags_i (flags),
    .busy_i  (busy_in),
    .word_o  (status_word),
    .irq_o   (err_irq)
  );

  assign active_mode = flags[FL_EN];
  assign master_sel  = flags[FL_MS];

endmodule

// File: rtl/sc_status_reg_chk.sv
module sc_status_reg_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        cmd_wr,
  input logic [15:0] cmd_data,
  input logic [5:0]  hw_err_evt,
  input logic [4:0]  err_en,
  input logic        busy_in,
  input logic [15:0] status_word,
  input logic        err_irq,
  input logic        active_mode,
  input logic        master_sel
);

  // R3
  en_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_wr && cmd_data[1] && !cmd_data[0] |=> status_word[0]);

  // R3
  te_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_wr && cmd_data[8] && !cmd_data[12] && !(hw_err_evt[1] && err_en[0]) |=> !status_word[8]);

  // R5
  en_conflict_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_wr && cmd_data[0] && cmd_data[1] |=> $stable(status_word[0]));

  // R4
  no_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !cmd_wr && hw_err_evt == 6'd0 |=> $stable(status_word[12:0]));

  // R6
  gated_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !cmd_wr && hw_err_evt[2] && !err_en[1] |=> $stable(status_word[9]));

  // R6
  me_always_chk: assert property (@(posedge clk) disable iff (!rst_n)
    hw_err_evt[0] |=> status_word[7]);

  // R7
  evt_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    hw_err_evt[5] && err_en[4] && cmd_wr && cmd_data[4] |=> status_word[12]);

  // R2
  layout_chk: assert property (@(posedge clk) disable iff (!rst_n)
    status_word[6:2] == 5'd0 && status_word[15:14] == 2'd0 && status_word[13] == busy_in);

  // R9
  irq_chk: assert property (@(posedge clk) disable iff (!rst_n)
    err_irq == (|status_word[12:7]));

  // R10
  mode_out_chk: assert property (@(posedge clk) disable iff (!rst_n)
    active_mode == status_word[0] && master_sel == status_word[1]);

endmodule

bind sc_status_reg sc_status_reg_chk u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .cmd_wr      (cmd_wr),
  .cmd_data    (cmd_data),
  .hw_err_evt  (hw_err_evt),
  .err_en      (err_en),
  .busy_in     (busy_in),
  .status_word (status_word),
  .err_irq     (err_irq),
  .active_mode (active_mode),
  .master_sel  (master_sel)
);

// File: tb/tb_sc_status_reg.sv
module tb_sc_status_reg;

  localparam int CLK_P = 10;
  localparam int NV    = 25;

  typedef struct packed {
    logic        wr;
    logic [15:0] data;
    logic [5:0]  evt;
    logic [4:0]  en;
    logic        busy;
    logic [15:0] exp;
  } vec_t;

  // each entry: one cycle of stimulus and the status word after that edge
  localparam vec_t VECS [NV] = '{
    '{1'b1, 16'h0002, 6'h00, 5'h00, 1'b0, 16'h0001}, // R3 set enable
    '{1'b1, 16'h0008, 6'h00, 5'h00, 1'b0, 16'h0003}, // R3 set master
    '{1'b1, 16'h1000, 6'h00, 5'h00, 1'b1, 16'h2103}, // R3 set tx err, R2 busy
    '{1'b1, 16'h2000, 6'h00, 5'h00, 1'b0, 16'h0303}, // R3 set rx err
    '{1'b1, 16'h4000, 6'h00, 5'h00, 1'b0, 16'h0703}, // R3 set abort
    '{1'b1, 16'h8000, 6'h00, 5'h00, 1'b0, 16'h0F03}, // R3 set tx underflow
    '{1'b1, 16'h0020, 6'h00, 5'h00, 1'b0, 16'h1F03}, // R3 set rx underflow
    '{1'b1, 16'h0080, 6'h00, 5'h00, 1'b0, 16'h1F83}, // R3 set mode err
    '{1'b1, 16'h0100, 6'h00, 5'h00, 1'b0, 16'h1E83}, // R3 clear tx err
    '{1'b1, 16'h0F50, 6'h00, 5'h00, 1'b0, 16'h0003}, // R8 bulk clear
    '{1'b1, 16'h0003, 6'h00, 5'h00, 1'b0, 16'h0003}, // R5 enable conflict
    '{1'b1, 16'h0001, 6'h00, 5'h00, 1'b0, 16'h0002}, // R3 R10 config mode
    '{1'b0, 16'h0000, 6'h01, 5'h00, 1'b0, 16'h0082}, // R6 mode always
    '{1'b0, 16'h0000, 6'h02, 5'h00, 1'b0, 16'h0082}, // R6 tx disabled
    '{1'b0, 16'h0000, 6'h02, 5'h01, 1'b0, 16'h0182}, // R6 tx enabled
    '{1'b1, 16'h0100, 6'h02, 5'h01, 1'b0, 16'h0182}, // R7 event beats clear
    '{1'b0, 16'h0000, 6'h3E, 5'h00, 1'b0, 16'h0182}, // R6 all gated off
    '{1'b0, 16'h0000, 6'h3F, 5'h1F, 1'b0, 16'h1F82}, // R6 all enabled
    '{1'b0, 16'h0F50, 6'h00, 5'h00, 1'b0, 16'h1F82}, // R4 no strobe
    '{1'b1, 16'h0F50, 6'h00, 5'h00, 1'b0, 16'h0002}, // R8 bulk clear
    '{1'b1, 16'h000C, 6'h00, 5'h00, 1'b0, 16'h0002}, // R5 master conflict
    '{1'b1, 16'h0004, 6'h00, 5'h00, 1'b0, 16'h0000}, // R3 clear master
    '{1'b1, 16'h00C0, 6'h00, 5'h00, 1'b0, 16'h0000}, // R5 mode conflict
    '{1'b1, 16'h0030, 6'h20, 5'h10, 1'b0, 16'h1000}, // R7 event beats conflict
    '{1'b1, 16'h0010, 6'h00, 5'h00, 1'b0, 16'h0000}  // R3 clear rx underflow
  };

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cmd_wr = 1'b0;
  logic [15:0] cmd_data = '0;
  logic [5:0]  hw_err_evt = '0;
  logic [4:0]  err_en = '0;
  logic        busy_in = 1'b0;
  logic [15:0] status_word;
  logic        err_irq;
  logic        active_mode;
  logic        master_sel;

  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;

  always #(CLK_P/2) clk = ~clk;

  sc_status_reg dut (
    .clk         (clk),
    .rst_n       (rst_n),
    .cmd_wr      (cmd_wr),
    .cmd_data    (cmd_data),
    .hw_err_evt  (hw_err_evt),
    .err_en      (err_en),
    .busy_in     (busy_in),
    .status_word (status_word),
    .err_irq     (err_irq),
    .active_mode (active_mode),
    .master_sel  (master_sel)
  );

  task automatic check_all(input string req, input logic [15:0] exp);
    logic [2:0] got, want;
    checks++;
    if (status_word !== exp) begin
      errors++;
      $display("FAIL %s status actual=%h expected=%h", req, status_word, exp);
    end
    checks++;
    got  = {err_irq, master_sel, active_mode};
    want = {|exp[12:7], exp[1], exp[0]};
    if (got !== want) begin
      errors++;
      $display("FAIL %s R9/R10 irq,ms,en actual=%b expected=%b", req, got, want);
    end
  endtask

  task automatic idle_inputs();
    cmd_wr = 1'b0; cmd_data = '0; hw_err_evt = '0; err_en = '0; busy_in = 1'b0;
  endtask

  initial begin
    #(CLK_P * 5000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    check_all("R1 reset", 16'h0000);
    rst_n = 1'b1;
    @(negedge clk);
    check_all("R1 after release", 16'h0000);

    for (int i = 0; i < NV; i++) begin
      cmd_wr = VECS[i].wr; cmd_data = VECS[i].data;
      hw_err_evt = VECS[i].evt; err_en = VECS[i].en; busy_in = VECS[i].busy;
      @(posedge clk);
      #1;
      check_all($sformatf("vector %0d", i), VECS[i].exp);
      @(negedge clk);
      idle_inputs();
    end

    // R2 busy mirrors with no clock edge
    busy_in = 1'b1;
    #1;
    check_all("R2 busy live", 16'h2000);
    busy_in = 1'b0;

    // R1 reset mid-run clears flags
    @(negedge clk);
    cmd_wr = 1'b1; cmd_data = 16'hF0AA;
    @(negedge clk);
    idle_inputs();
    check_all("R3 multi set", 16'h1F83);
    rst_n = 1'b0;
    #1;
    check_all("R1 mid-run reset", 16'h0000);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check_all("R1 held after reset", 16'h0000);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule